// File: doc/BRIEF.md
# Pipelined Integer ALU with Dedicated Compare Subtractor

This block is a parameterised integer arithmetic and logic unit built around two adder/subtractor datapaths that run side by side. The main adder produces the sum or difference for add and subtract. A second subtractor always forms A minus B. Its carry, sign and overflow outputs decide compare outcomes and choose the operand for min and max. No operation has to wait for the main adder to finish before the operand order is known.

The unit is a two-stage pipeline. Stage one registers both adder outputs, their flags, the operands and the decoded control strobes. Stage two picks the final result, updates the status flags and raises the output strobe. A new operation can enter on every cycle. The opcode is five bits wide. Bit 4 selects signed (1) or unsigned (0) ordering for compare, min and max. Bits 3:0 hold the operation code: 0 add, 1 subtract, 2 compare, 3 min, 4 max, 5 AND, 6 OR, 7 XOR, 8 NOT (bitwise inverse of A). Codes 9 to 15 are illegal.

The flags output carries four bits: bit 3 zero, bit 2 negative (result MSB), bit 1 carry, bit 0 overflow. The flags are held between updates.

Top module: `aluDualAdder`

## Requirements
- R1: A strobe on `inValid` at a clock edge produces `outValid` exactly two edges later. Operations may be issued on consecutive cycles, and each one appears in issue order.
- R2: For add (code 0) the result is A+B mod 2^W, carry is the carry out, and overflow is signed overflow. For subtract (code 1) the result is A−B mod 2^W, carry is 1 when A ≥ B unsigned, and overflow is signed overflow of A−B. Zero and negative flags come from the result. `resWrEn` is 1.
- R3: Compare (code 2) leaves `resWrEn` at 0. It sets the flags from A−B: zero when A equals B, negative from the MSB of the difference, carry when A ≥ B unsigned, overflow on signed overflow.
- R4: With opcode bit 4 clear, min (code 3) returns B when A ≥ B unsigned and A otherwise. Max (code 4) returns the other operand.
- R5: With opcode bit 4 set, min and max use signed two's-complement order on the same selection rule.
- R6: Codes 5, 6 and 7 return A AND B, A OR B and A XOR B. Code 8 returns the bitwise inverse of A and ignores B.
- R7: For min, max and the four bitwise operations, zero and negative come from the result, and carry and overflow are cleared.
- R8: An illegal code (9 to 15) with `inValid` still produces `outValid`. It keeps `resWrEn` at 0 and leaves the flags unchanged. The flags also hold across cycles with no valid operation.
- R9: A synchronous active-high reset clears `outValid`, `resWrEn` and all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| opCode | input | 5 | Bit 4 signed order, bits 3:0 operation |
| opA | input | WIDTH | Operand A |
| opB | input | WIDTH | Operand B |
| outValid | output | 1 | Result strobe, two cycles after input |
| resWrEn | output | 1 | Result should be written back |
| result | output | WIDTH | Selected result |
| flags | output | 4 | {zero, negative, carry, overflow} |

## Verification
Seeded random operand pairs over all sixteen operation codes and both order modes exercise the two adders across their full range, with flags compared after every operation. Directed cases follow. Equal operands tell the strict and non-strict selection rules apart. Pairs whose MSBs differ make signed and unsigned min/max disagree, which shows that bit 4 is honoured. The most negative value minus one and the most positive value plus one separate the carry flag from the overflow flag. A compare issued after a result-writing operation, and illegal codes issued between flag-setting operations, show that the flags hold while no result is written. Back-to-back issue checks ordering and the fixed two-cycle latency.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 4;
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_MIN = 4'd3,
    OP_MAX = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      isArith;
    logic      isCmp;
    logic      isMin;
    logic      isMax;
    logicSel_e logicSel;
    logic      signedCmp;
    logic      writeRes;
    logic      updFlags;
  } aluStrobe_t;

endpackage

// File: rtl/aluAddSub.sv
module aluAddSub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   full;

  always_comb begin
    bEff  = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, bEff} + {{WIDTH{1'b0}}, sub};
    sum   = full[WIDTH-1:0];
    carry = full[WIDTH];
    ovf   = (a[MSB] == bEff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OP_W-1:0] opCode,
  output logic            decSub,
  output aluStrobe_t      s1Strobe,
  output logic            s1Valid,
  output logic            outValid
);
  aluStrobe_t decStrobe;

  always_comb begin
    decStrobe           = '0;
    decStrobe.signedCmp = opCode[4];
    decSub              = 1'b0;
    case (aluOp_e'(opCode[3:0]))
      OP_ADD: begin
        decStrobe.isArith = 1'b1; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_SUB: begin
        decStrobe.isArith = 1'b1; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
        decSub = 1'b1;
      end
      OP_CMP: begin
        decStrobe.isCmp = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_MIN: begin
        decStrobe.isMin = 1'b1; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_MAX: begin
        decStrobe.isMax = 1'b1; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_AND: begin
        decStrobe.logicSel = LG_AND; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_OR: begin
        decStrobe.logicSel = LG_OR; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_XOR: begin
        decStrobe.logicSel = LG_XOR; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      OP_NOT: begin
        decStrobe.logicSel = LG_NOT; decStrobe.writeRes = 1'b1; decStrobe.updFlags = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Strobe <= '0;
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Strobe <= decStrobe;
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  // R1: fixed two-cycle latency from issue to output strobe
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  // R9: nothing is in flight in the cycle right after reset
  assert_reset_clear_R9: assert property (@(posedge clk)
    $fell(rst) |-> !outValid && !s1Valid);
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              decSub,
  input  aluStrobe_t        s1Strobe,
  input  logic              s1Valid,
  output logic [WIDTH-1:0]  result,
  output logic              resWrEn,
  output logic [FLAG_W-1:0] flags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] arithSum, cmpDiff;
  logic             arithCarry, arithOvf, cmpCarry, cmpOvf;

  aluAddSub #(.WIDTH(WIDTH)) u_arithAdder (
    .a(opA), .b(opB), .sub(decSub),
    .sum(arithSum), .carry(arithCarry), .ovf(arithOvf)
  );

  aluAddSub #(.WIDTH(WIDTH)) u_cmpAdder (
    .a(opA), .b(opB), .sub(1'b1),
    .sum(cmpDiff), .carry(cmpCarry), .ovf(cmpOvf)
  );

  // stage one registers
  logic [WIDTH-1:0] s1Sum, s1Diff, s1A, s1B;
  logic             s1C1, s1V1, s1C2, s1V2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Sum <= '0; s1Diff <= '0; s1A <= '0; s1B <= '0;
      s1C1 <= 1'b0; s1V1 <= 1'b0; s1C2 <= 1'b0; s1V2 <= 1'b0;
    end else begin
      s1Sum  <= arithSum;
      s1C1   <= arithCarry;
      s1V1   <= arithOvf;
      s1Diff <= cmpDiff;
      s1C2   <= cmpCarry;
      s1V2   <= cmpOvf;
      s1A    <= opA;
      s1B    <= opB;
    end
  end

  // stage two selection
  logic             aGeB, geUns, geSgn;
  logic [WIDTH-1:0] logicRes, selRes;
  logic             selC, selV;
  logic [FLAG_W-1:0] nextFlags;

  always_comb begin
    geUns = s1C2;
    geSgn = ~(s1Diff[MSB] ^ s1V2);
    aGeB  = s1Strobe.signedCmp ? geSgn : geUns;

    case (s1Strobe.logicSel)
      LG_AND:  logicRes = s1A & s1B;
      LG_OR:   logicRes = s1A | s1B;
      LG_XOR:  logicRes = s1A ^ s1B;
      default: logicRes = ~s1A;
    endcase

    selC = 1'b0;
    selV = 1'b0;
    if (s1Strobe.isArith) begin
      selRes = s1Sum; selC = s1C1; selV = s1V1;
    end else if (s1Strobe.isCmp) begin
      selRes = s1Diff; selC = s1C2; selV = s1V2;
    end else if (s1Strobe.isMin) begin
      selRes = aGeB ? s1B : s1A;
    end else if (s1Strobe.isMax) begin
      selRes = aGeB ? s1A : s1B;
    end else begin
      selRes = logicRes;
    end

    nextFlags         = '0;
    nextFlags[FLAG_Z] = (selRes == '0);
    nextFlags[FLAG_N] = selRes[MSB];
    nextFlags[FLAG_C] = selC;
    nextFlags[FLAG_V] = selV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      resWrEn <= 1'b0;
      flags   <= '0;
    end else begin
      resWrEn <= s1Valid && s1Strobe.writeRes;
      if (s1Valid) result <= selRes;
      if (s1Valid && s1Strobe.updFlags) flags <= nextFlags;
    end
  end

  // R3: compare carry reports unsigned A >= B
  assert_cmp_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && s1Strobe.isCmp) |=> (flags[FLAG_C] == ($past(s1A) >= $past(s1B))));

  // R4: min/max always return one of the two operands
  assert_minmax_pick_R4: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && (s1Strobe.isMin || s1Strobe.isMax)) |=>
      (result == $past(s1A) || result == $past(s1B)));

  // R5: signed min never exceeds either operand
  assert_signed_min_R5: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && s1Strobe.isMin && s1Strobe.signedCmp) |=>
      ($signed(result) <= $signed($past(s1A)) && $signed(result) <= $signed($past(s1B))));

  // R8: flags hold when no flag-updating operation retires
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(s1Valid && s1Strobe.updFlags) |=> $stable(flags));

  // R3: a compare never requests a write
  assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && s1Strobe.isCmp) |=> !resWrEn);
endmodule

// File: rtl/aluDualAdder.sv
module aluDualAdder
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic              outValid,
  output logic              resWrEn,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flags
);
  logic       decSub;
  logic       s1Valid;
  aluStrobe_t s1Strobe;

  aluCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .decSub(decSub), .s1Strobe(s1Strobe), .s1Valid(s1Valid), .outValid(outValid)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .decSub(decSub),
    .s1Strobe(s1Strobe), .s1Valid(s1Valid),
    .result(result), .resWrEn(resWrEn), .flags(flags)
  );

  // R8: a write request only ever comes with the output strobe
  assert_wren_valid_R8: assert property (@(posedge clk) disable iff (rst)
    resWrEn |-> outValid);
endmodule

// File: tb/aluDualAdder_bench.sv
module aluDualAdder_bench;
  localparam int W = 8;
  localparam int MSB = W - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [4:0]   opCode = '0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         outValid, resWrEn;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aluDualAdder #(.WIDTH(W)) u_aluDualAdder (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode), .opA(opA), .opB(opB),
    .outValid(outValid), .resWrEn(resWrEn), .result(result), .flags(flags)
  );

  typedef struct {
    bit           v;
    bit           wr;
    logic [W-1:0] res;
    logic [3:0]   fl;
    string        tag;
  } expEntry_t;

  expEntry_t pipe1, pipe2;
  logic [3:0] modelFlags = '0;

  function automatic expEntry_t model(bit v, logic [4:0] op, logic [W-1:0] a,
                                      logic [W-1:0] b, logic [3:0] prev);
    expEntry_t e;
    logic [W:0] full;
    logic [W-1:0] r;
    bit c, ov, ge, upd;
    e.v = v; e.wr = 0; e.res = '0; e.fl = prev; e.tag = "R1";
    c = 0; ov = 0; upd = 1; r = '0;
    case (op[3:0])
      4'd0: begin full = a + b; r = full[W-1:0]; c = full[W];
              ov = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]); e.wr = 1; e.tag = "R2"; end
      4'd1, 4'd2: begin r = a - b; c = (a >= b);
              ov = (a[MSB] != b[MSB]) && (r[MSB] != a[MSB]);
              e.wr = (op[3:0] == 4'd1); e.tag = (op[3:0] == 4'd1) ? "R2" : "R3"; end
      4'd3, 4'd4: begin
              ge = op[4] ? ($signed(a) >= $signed(b)) : (a >= b);
              r = (op[3:0] == 4'd3) ? (ge ? b : a) : (ge ? a : b);
              e.wr = 1; e.tag = op[4] ? "R5" : "R4"; end
      4'd5: begin r = a & b; e.wr = 1; e.tag = "R6"; end
      4'd6: begin r = a | b; e.wr = 1; e.tag = "R6"; end
      4'd7: begin r = a ^ b; e.wr = 1; e.tag = "R6"; end
      4'd8: begin r = ~a;    e.wr = 1; e.tag = "R6"; end
      default: begin upd = 0; e.tag = "R8"; end
    endcase
    e.res = r;
    if (v && upd) e.fl = {(r == '0), r[MSB], c, ov};
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkOut();
    check(outValid == pipe2.v, "R1", "outValid", outValid, pipe2.v);
    check(resWrEn == (pipe2.v && pipe2.wr), pipe2.tag, "resWrEn", resWrEn, pipe2.v && pipe2.wr);
    if (pipe2.v && pipe2.wr) check(result == pipe2.res, pipe2.tag, "result", result, pipe2.res);
    check(flags == pipe2.fl, (pipe2.tag == "R4" || pipe2.tag == "R5" || pipe2.tag == "R6") ? "R7" : pipe2.tag,
          "flags", flags, pipe2.fl);
  endtask

  task automatic step(bit v, logic [4:0] op, logic [W-1:0] a, logic [W-1:0] b);
    expEntry_t e;
    @(negedge clk);
    checkOut();
    e = model(v, op, a, b, modelFlags);
    if (v) modelFlags = e.fl;
    pipe2 = pipe1;
    pipe1 = e;
    inValid = v; opCode = op; opA = a; opB = b;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pipe1 = '{v: 0, wr: 0, res: '0, fl: '0, tag: "R9"};
    pipe2 = pipe1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 0, "R9", "outValid in reset", outValid, 0);
    check(resWrEn == 0, "R9", "resWrEn in reset", resWrEn, 0);
    check(flags == 4'h0, "R9", "flags in reset", flags, 0);
    rst = 1'b0;

    // R2 carry vs overflow corners
    step(1, 5'd0, 8'h7F, 8'h01);
    step(1, 5'd0, 8'hFF, 8'h01);
    step(1, 5'd1, 8'h80, 8'h01);
    step(1, 5'd1, 8'h01, 8'h02);
    // R3: compare after a write; equal operands
    step(1, 5'd2, 8'h33, 8'h33);
    step(1, 5'd2, 8'h10, 8'h20);
    // R8: illegal codes keep flags, no write
    step(1, 5'd12, 8'h00, 8'h00);
    step(0, 5'd0, 8'h00, 8'h00);
    step(1, 5'd31, 8'hFF, 8'hFF);
    // R4 / R5: MSB differs so order modes disagree; equal operands
    step(1, 5'd3, 8'h90, 8'h10);
    step(1, 5'd19, 8'h90, 8'h10);
    step(1, 5'd4, 8'h90, 8'h10);
    step(1, 5'd20, 8'h90, 8'h10);
    step(1, 5'd3, 8'h44, 8'h44);
    step(1, 5'd20, 8'h7F, 8'h80);
    // R6 / R7 logic ops
    step(1, 5'd5, 8'hF0, 8'h0F);
    step(1, 5'd6, 8'hA0, 8'h05);
    step(1, 5'd7, 8'hAA, 8'hAA);
    step(1, 5'd8, 8'h00, 8'h5A);
    // R1 random back-to-back traffic
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, 5'($urandom), W'($urandom), W'($urandom));
    end
    step(0, 5'd0, 8'h00, 8'h00);
    step(0, 5'd0, 8'h00, 8'h00);
    step(0, 5'd0, 8'h00, 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule